// File: doc/BRIEF.md
# Four-Channel to 4:2:2 Plus Key Serializer

This block accepts one pixel at a time as four parallel unsigned channels (luma, blue difference, red difference and key), with a valid strobe and a line-active level. In serial mode it turns every pair of pixels into four consecutive words of a 4:2:2 component stream. A second stream carries the same layout, with the key sample in each luma slot and the colour blanking level in each chroma slot. The two streams share one valid strobe and stay aligned word for word. The block can also frame each active line with four-word start and end timing references in both streams.

The source can be taken as full 4:4:4:4, where both chroma samples of a pair come from the even pixel. It can also be taken as 4:2:2:4, where the red difference sample comes from the odd pixel. A narrow mode limits every word to 8 bits. Serial mode is entered only when the upstream word has been reduced to a plain unsigned video width (`cfg_reduced`). In every other case the four channels are passed out in parallel, one register late.

Usage contract: in serial mode, valid pixels are at least two cycles apart. No pixel is sampled in the two cycles that follow a rise of `line_active`. `line_active` falls no earlier than four cycles after the last pixel. Configuration changes only while the block is idle.

Top module: `key422_mux`

## Requirements
- R1: After reset, `mux_valid` and `par_valid` are low and every data output is zero.
- R2: Serial mode is active only while both `cfg_muxed` and `cfg_reduced` are 1. Otherwise `mux_valid` never rises, and no words, including timing references, appear on the serial ports.
- R3: In parallel mode, each sampled pixel appears unchanged on `par_y`, `par_cb`, `par_cr` and `par_key` with `par_valid` high, one clock edge after the edge that sampled it.
- R4: Pixels of a line are paired from the first (even) pixel. The odd pixel's edge starts four serial words on the next four edges, in the order blue difference, even luma, red difference, odd luma.
- R5: With `cfg_src422`=0, both chroma words of a pair are taken from the even pixel.
- R6: With `cfg_src422`=1, the blue difference word comes from the even pixel and the red difference word from the odd pixel.
- R7: `mux_key` carries the even key in the even-luma slot and the odd key in the odd-luma slot. Both chroma slots carry the blanking level: 512 in 10-bit mode, 128 in narrow mode.
- R8: With `cfg_8bit`=1, only bits 7:0 of every input channel are used, and bits 9:8 of every serial word are zero.
- R9: With `cfg_trs_en`=1, a rise of `line_active` (start, H=0) or a fall (end, H=1) emits four words in both streams on the next four edges: all-ones, 0, 0, then a status word. The status word is bit9=1, bit8=F, bit7=V, bit6=H, bit5=V^H, bit4=F^H, bit3=F^V, bit2=F^V^H, bits1:0=0. In narrow mode the words are 0xFF, 0, 0 and status bits 9:2.
- R10: With `cfg_trs_en`=0, line edges add no words to either stream.
- R11: When a line has an odd number of pixels, the last pixel produces no serial words.
- R12: When pixels arrive every second cycle, consecutive pairs, and timing references adjoining pairs, leave one unbroken run of valid words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_muxed | input | 1 | Request serial 4:2:2 output |
| cfg_reduced | input | 1 | Upstream data is at plain unsigned video width |
| cfg_src422 | input | 1 | 0: 4:4:4:4 source, 1: 4:2:2:4 source |
| cfg_8bit | input | 1 | Narrow 8-bit words |
| cfg_trs_en | input | 1 | Insert timing reference words |
| fld_f | input | 1 | Field bit for timing references |
| vbl_v | input | 1 | Vertical blanking bit for timing references |
| line_active | input | 1 | High across the active part of a line |
| in_valid | input | 1 | Pixel strobe |
| in_y | input | DATA_W | Luma sample |
| in_cb | input | DATA_W | Blue difference sample |
| in_cr | input | DATA_W | Red difference sample |
| in_key | input | DATA_W | Key sample |
| mux_valid | output | 1 | Serial word strobe |
| mux_main | output | DATA_W | Serial 4:2:2 word |
| mux_key | output | DATA_W | Serial key word |
| par_valid | output | 1 | Parallel pixel strobe |
| par_y | output | DATA_W | Parallel luma |
| par_cb | output | DATA_W | Parallel blue difference |
| par_cr | output | DATA_W | Parallel red difference |
| par_key | output | DATA_W | Parallel key |

## Verification
Parallel results are due one edge after the pixel's sampling edge. The bench checks them at the falling edge that follows. Each serial word is stamped with the count of the rising edge that registered it. A pair is due on the four edges after its odd pixel, and a timing reference on the four edges after the line edge is sampled. The bench builds its expected list with those stamps and compares word, key word and stamp one by one. A missing, extra or late word is therefore caught, and so is a gap between adjacent groups.

// File: rtl/key422_pkg.sv
package key422_pkg;

  // words emitted per pixel pair or per timing reference
  localparam int GROUP_WORDS = 4;

  // status word of a timing reference, 10-bit form
  function automatic logic [9:0] status_word10(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

endpackage

// File: rtl/key422_pairer.sv
module key422_pairer #(
  parameter int DATA_W = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enable,
  input  logic                               src422,
  input  logic                               narrow,
  input  logic                               line_active,
  input  logic                               in_valid,
  input  logic [DATA_W-1:0]                  in_y,
  input  logic [DATA_W-1:0]                  in_cb,
  input  logic [DATA_W-1:0]                  in_cr,
  input  logic [DATA_W-1:0]                  in_key,
  output logic                               pair_load,
  output logic [key422_pkg::GROUP_WORDS*DATA_W-1:0] pair_main,
  output logic [key422_pkg::GROUP_WORDS*DATA_W-1:0] pair_key
);
  localparam int NARROW_W = DATA_W - 2;
  localparam logic [DATA_W-1:0] NARROW_MASK  = {2'b00, {NARROW_W{1'b1}}};
  localparam logic [DATA_W-1:0] BLANK_WIDE   = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] BLANK_NARROW = {3'b001, {(DATA_W-3){1'b0}}};

  logic              odd_phase;
  logic [DATA_W-1:0] ev_y, ev_cb, ev_cr, ev_key;
  logic [DATA_W-1:0] y_m, cb_m, cr_m, k_m, blank, cr_sel;

  // narrow mode keeps only the low bits of each channel
  always_comb begin
    y_m   = narrow ? (in_y   & NARROW_MASK) : in_y;
    cb_m  = narrow ? (in_cb  & NARROW_MASK) : in_cb;
    cr_m  = narrow ? (in_cr  & NARROW_MASK) : in_cr;
    k_m   = narrow ? (in_key & NARROW_MASK) : in_key;
    blank = narrow ? BLANK_NARROW : BLANK_WIDE;
  end

  assign pair_load = enable & line_active & in_valid & odd_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_phase <= 1'b0;
      ev_y      <= '0;
      ev_cb     <= '0;
      ev_cr     <= '0;
      ev_key    <= '0;
    end else if (!line_active || !enable) begin
      odd_phase <= 1'b0;        // an unpaired last pixel is dropped here
    end else if (in_valid) begin
      odd_phase <= ~odd_phase;
      if (!odd_phase) begin
        ev_y   <= y_m;
        ev_cb  <= cb_m;
        ev_cr  <= cr_m;
        ev_key <= k_m;
      end
    end
  end

  assign cr_sel = src422 ? cr_m : ev_cr;

  // word 0 sits in the low bits and leaves first
  assign pair_main = {y_m, cr_sel, ev_y, ev_cb};
  assign pair_key  = {k_m, blank, ev_key, blank};

  // R12
  in_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && line_active && in_valid) |=> !in_valid);

endmodule

// File: rtl/key422_trs.sv
module key422_trs #(
  parameter int DATA_W = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               enable,
  input  logic                               trs_en,
  input  logic                               narrow,
  input  logic                               line_active,
  input  logic                               fld_f,
  input  logic                               vbl_v,
  output logic                               trs_load,
  output logic [key422_pkg::GROUP_WORDS*DATA_W-1:0] trs_words
);
  localparam int NARROW_W = DATA_W - 2;
  localparam logic [DATA_W-1:0] NARROW_MASK = {2'b00, {NARROW_W{1'b1}}};

  logic              la_q;
  logic [9:0]        stat10;
  logic [DATA_W-1:0] stat_full, stat_word, ones_word;

  always_ff @(posedge clk) begin
    if (rst) la_q <= 1'b0;
    else     la_q <= line_active;
  end

  assign trs_load  = enable & trs_en & (line_active ^ la_q);
  assign stat10    = key422_pkg::status_word10(fld_f, vbl_v, ~line_active);
  assign stat_full = DATA_W'(stat10) << (DATA_W - 10);
  assign stat_word = narrow ? (stat_full >> 2) : stat_full;
  assign ones_word = narrow ? NARROW_MASK : {DATA_W{1'b1}};
  assign trs_words = {stat_word, {DATA_W{1'b0}}, {DATA_W{1'b0}}, ones_word};

  // R9
  trs_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    trs_load |=> !trs_load);

endmodule

// File: rtl/key422_serializer.sv
module key422_serializer #(
  parameter int DATA_W = 10
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               load,
  input  logic [key422_pkg::GROUP_WORDS*DATA_W-1:0] load_main,
  input  logic [key422_pkg::GROUP_WORDS*DATA_W-1:0] load_key,
  output logic                               out_valid,
  output logic [DATA_W-1:0]                  out_main,
  output logic [DATA_W-1:0]                  out_key
);
  localparam int GROUP = key422_pkg::GROUP_WORDS;
  localparam int CNT_W = $clog2(GROUP + 1);

  logic [GROUP*DATA_W-1:0] sh_m, sh_k;
  logic [CNT_W-1:0]        cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh_m      <= '0;
      sh_k      <= '0;
      out_valid <= 1'b0;
      out_main  <= '0;
      out_key   <= '0;
    end else begin
      if (cnt != '0) begin
        out_valid <= 1'b1;
        out_main  <= sh_m[DATA_W-1:0];
        out_key   <= sh_k[DATA_W-1:0];
        sh_m      <= sh_m >> DATA_W;
        sh_k      <= sh_k >> DATA_W;
        cnt       <= cnt - CNT_W'(1);
      end else begin
        out_valid <= 1'b0;
      end
      // a new group may load while the last word of the old one leaves
      if (load) begin
        sh_m <= load_main;
        sh_k <= load_key;
        cnt  <= CNT_W'(GROUP);
      end
    end
  end

  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> (cnt <= CNT_W'(1)));

endmodule

// File: rtl/key422_parallel.sv
module key422_parallel #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_y,
  input  logic [DATA_W-1:0] in_cb,
  input  logic [DATA_W-1:0] in_cr,
  input  logic [DATA_W-1:0] in_key,
  output logic              par_valid,
  output logic [DATA_W-1:0] par_y,
  output logic [DATA_W-1:0] par_cb,
  output logic [DATA_W-1:0] par_cr,
  output logic [DATA_W-1:0] par_key
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_valid <= 1'b0;
      par_y     <= '0;
      par_cb    <= '0;
      par_cr    <= '0;
      par_key   <= '0;
    end else begin
      par_valid <= active & in_valid;
      if (active && in_valid) begin
        par_y   <= in_y;
        par_cb  <= in_cb;
        par_cr  <= in_cr;
        par_key <= in_key;
      end
    end
  end
endmodule

// File: rtl/key422_mux.sv
module key422_mux #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_muxed,
  input  logic              cfg_reduced,
  input  logic              cfg_src422,
  input  logic              cfg_8bit,
  input  logic              cfg_trs_en,
  input  logic              fld_f,
  input  logic              vbl_v,
  input  logic              line_active,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_y,
  input  logic [DATA_W-1:0] in_cb,
  input  logic [DATA_W-1:0] in_cr,
  input  logic [DATA_W-1:0] in_key,
  output logic              mux_valid,
  output logic [DATA_W-1:0] mux_main,
  output logic [DATA_W-1:0] mux_key,
  output logic              par_valid,
  output logic [DATA_W-1:0] par_y,
  output logic [DATA_W-1:0] par_cb,
  output logic [DATA_W-1:0] par_cr,
  output logic [DATA_W-1:0] par_key
);
  localparam int GW = key422_pkg::GROUP_WORDS * DATA_W;

  logic          mux_en;
  logic          pair_load, trs_load, grp_load;
  logic [GW-1:0] pair_main, pair_key, trs_words, grp_main, grp_key;

  // serial mode only at a reduced unsigned word width
  assign mux_en = cfg_muxed & cfg_reduced;

  key422_pairer #(.DATA_W(DATA_W)) u_pair (
    .clk(clk), .rst(rst), .enable(mux_en), .src422(cfg_src422), .narrow(cfg_8bit),
    .line_active(line_active), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
    .pair_load(pair_load), .pair_main(pair_main), .pair_key(pair_key));

  key422_trs #(.DATA_W(DATA_W)) u_trs (
    .clk(clk), .rst(rst), .enable(mux_en), .trs_en(cfg_trs_en), .narrow(cfg_8bit),
    .line_active(line_active), .fld_f(fld_f), .vbl_v(vbl_v),
    .trs_load(trs_load), .trs_words(trs_words));

  assign grp_load = pair_load | trs_load;
  assign grp_main = trs_load ? trs_words : pair_main;
  assign grp_key  = trs_load ? trs_words : pair_key;

  key422_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .load(grp_load), .load_main(grp_main), .load_key(grp_key),
    .out_valid(mux_valid), .out_main(mux_main), .out_key(mux_key));

  key422_parallel #(.DATA_W(DATA_W)) u_par (
    .clk(clk), .rst(rst), .active(~mux_en), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
    .par_valid(par_valid), .par_y(par_y), .par_cb(par_cb), .par_cr(par_cr), .par_key(par_key));

  // R9
  no_collision_chk: assert property (@(posedge clk) disable iff (rst)
    !(pair_load && trs_load));

  // R2
  par_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(mux_valid && par_valid));

  // R2
  mux_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mux_valid) |-> $past(mux_en));

  // R3
  par_src_chk: assert property (@(posedge clk) disable iff (rst)
    par_valid |-> $past(in_valid && !mux_en));

endmodule

// File: tb/key422_mux_test.sv
`timescale 1ns/1ps
module key422_mux_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_muxed, cfg_reduced, cfg_src422, cfg_8bit, cfg_trs_en;
  logic       fld_f, vbl_v, line_active, in_valid;
  logic [9:0] in_y, in_cb, in_cr, in_key;
  logic       mux_valid, par_valid;
  logic [9:0] mux_main, mux_key, par_y, par_cb, par_cr, par_key;

  always #2 clk = ~clk;

  key422_mux uut (
    .clk(clk), .rst(rst), .cfg_muxed(cfg_muxed), .cfg_reduced(cfg_reduced),
    .cfg_src422(cfg_src422), .cfg_8bit(cfg_8bit), .cfg_trs_en(cfg_trs_en),
    .fld_f(fld_f), .vbl_v(vbl_v), .line_active(line_active), .in_valid(in_valid),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .in_key(in_key),
    .mux_valid(mux_valid), .mux_main(mux_main), .mux_key(mux_key),
    .par_valid(par_valid), .par_y(par_y), .par_cb(par_cb), .par_cr(par_cr), .par_key(par_key));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // capture of serial words, stamped with the edge count that registered them
  logic [9:0] cm [64];
  logic [9:0] ck [64];
  int         ct [64];
  int         ncap = 0;
  logic [9:0] em [64];
  logic [9:0] ek [64];
  int         et [64];
  int         ne = 0;

  always @(negedge clk) begin
    if (!rst && mux_valid && ncap < 64) begin
      cm[ncap] = mux_main;
      ck[ncap] = mux_key;
      ct[ncap] = cyc;
      ncap = ncap + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] mk(input bit nar, input logic [9:0] v);
    return nar ? (v & 10'h0FF) : v;
  endfunction

  function automatic logic [9:0] stat(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h, 2'b00};
  endfunction

  task automatic push(input logic [9:0] m, input logic [9:0] k, input int t);
    em[ne] = m; ek[ne] = k; et[ne] = t; ne++;
  endtask

  task automatic push_trs(input bit nar, input bit f, input bit v, input bit h, input int base);
    logic [9:0] s;
    s = nar ? (stat(f, v, h) >> 2) : stat(f, v, h);
    push(nar ? 10'h0FF : 10'h3FF, nar ? 10'h0FF : 10'h3FF, base + 1);
    push(10'h000, 10'h000, base + 2);
    push(10'h000, 10'h000, base + 3);
    push(s, s, base + 4);
  endtask

  task automatic drive_pixel(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr,
                             input logic [9:0] k, output int t);
    in_valid = 1'b1; in_y = y; in_cb = cb; in_cr = cr; in_key = k;
    @(negedge clk);
    t = cyc;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_line(output int t);
    line_active = 1'b1;
    @(negedge clk);
    t = cyc;
    @(negedge clk);
  endtask

  task automatic end_line(output int t);
    repeat (2) @(negedge clk);
    line_active = 1'b0;
    @(negedge clk);
    t = cyc;
    repeat (7) @(negedge clk);
  endtask

  task automatic compare(input string req_main, input string req_cnt);
    chk(ncap == ne, req_cnt, "word count", ncap, ne);
    for (int i = 0; i < ne && i < ncap; i++) begin
      chk(cm[i] == em[i], req_main, $sformatf("main word %0d", i), cm[i], em[i]);
      chk(ck[i] == ek[i], "R7", $sformatf("key word %0d", i), ck[i], ek[i]);
      chk(ct[i] == et[i], "R4/R12", $sformatf("stamp of word %0d", i), ct[i], et[i]);
    end
  endtask

  task automatic run_line(input bit s422, input bit nar, input bit trs, input bit f, input bit v,
                          input int npix, input string req_main, input string req_cnt);
    int r, t, fl;
    logic [9:0] y, cb, cr, k, ey, ecb, ecr, ekk, blank;
    cfg_src422 = s422; cfg_8bit = nar; cfg_trs_en = trs; fld_f = f; vbl_v = v;
    blank = nar ? 10'd128 : 10'd512;
    ey = '0; ecb = '0; ecr = '0; ekk = '0;
    @(negedge clk);
    ncap = 0; ne = 0;
    start_line(r);
    if (trs) push_trs(nar, f, v, 1'b0, r);
    for (int i = 0; i < npix; i++) begin
      y  = 10'h300 + 10'(i * 17);
      cb = 10'h240 + 10'(i * 5);
      cr = 10'h1C0 + 10'(i * 3);
      k  = 10'h3A0 - 10'(i * 7);
      drive_pixel(y, cb, cr, k, t);
      if (i % 2 == 0) begin
        ey = y; ecb = cb; ecr = cr; ekk = k;
      end else begin
        push(mk(nar, ecb), blank, t + 1);
        push(mk(nar, ey), mk(nar, ekk), t + 2);
        push(s422 ? mk(nar, cr) : mk(nar, ecr), blank, t + 3);
        push(mk(nar, y), mk(nar, k), t + 4);
      end
    end
    end_line(fl);
    if (trs) push_trs(nar, f, v, 1'b1, fl);
    compare(req_main, req_cnt);
  endtask

  task automatic test_reset;
    rst = 1'b1;
    cfg_muxed = 1'b0; cfg_reduced = 1'b0; cfg_src422 = 1'b0; cfg_8bit = 1'b0; cfg_trs_en = 1'b0;
    fld_f = 1'b0; vbl_v = 1'b0; line_active = 1'b0; in_valid = 1'b0;
    in_y = '0; in_cb = '0; in_cr = '0; in_key = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mux_valid && !par_valid, "R1", "valids after reset", {mux_valid, par_valid}, 0);
    chk(mux_main == 0 && mux_key == 0, "R1", "serial data after reset", {mux_main, mux_key}, 0);
    chk((par_y | par_cb | par_cr | par_key) == 0, "R1", "parallel data after reset",
        par_y | par_cb | par_cr | par_key, 0);
  endtask

  task automatic par_pixel(input logic [9:0] y, input logic [9:0] cb, input logic [9:0] cr,
                           input logic [9:0] k);
    in_valid = 1'b1; in_y = y; in_cb = cb; in_cr = cr; in_key = k;
    @(negedge clk);
    chk(par_valid, "R3", "par_valid after pixel", par_valid, 1);
    chk(par_y == y && par_cb == cb, "R3", "par luma/blue", {par_y, par_cb}, {y, cb});
    chk(par_cr == cr && par_key == k, "R3", "par red/key", {par_cr, par_key}, {cr, k});
    chk(!mux_valid, "R2", "no serial word in parallel mode", mux_valid, 0);
    in_valid = 1'b0;
    @(negedge clk);
    chk(!par_valid, "R3", "par_valid drops", par_valid, 0);
  endtask

  task automatic test_parallel;
    cfg_muxed = 1'b0; cfg_reduced = 1'b1;
    @(negedge clk);
    par_pixel(10'h3FF, 10'h001, 10'h2AA, 10'h155);
    par_pixel(10'h123, 10'h321, 10'h0F0, 10'h30F);
  endtask

  task automatic test_gated;
    int r, t, fl;
    cfg_muxed = 1'b1; cfg_reduced = 1'b0; cfg_trs_en = 1'b1;
    @(negedge clk);
    ncap = 0;
    start_line(r);
    drive_pixel(10'h111, 10'h222, 10'h333, 10'h044, t);
    drive_pixel(10'h155, 10'h266, 10'h377, 10'h088, t);
    end_line(fl);
    chk(ncap == 0, "R2", "serial words while not reduced", ncap, 0);
    par_pixel(10'h0AB, 10'h0CD, 10'h0EF, 10'h012);
  endtask

  initial begin
    test_reset();
    test_parallel();
    test_gated();
    cfg_muxed = 1'b1; cfg_reduced = 1'b1;
    run_line(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4, "R4 R5", "R10");   // two pairs, no references
    run_line(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2, "R6", "R4");
    run_line(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2, "R8", "R8");
    run_line(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2, "R9", "R9");
    run_line(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4, "R9 R8", "R12");
    run_line(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R11", "R11");
    run_line(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1, "R11", "R11");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule